// File: doc/BRIEF.md
# Coprocessor Register Scan Chain

This block sits behind a debug test access port and lets an external host reach the system-control coprocessor registers over a 48-bit data register. An outside TAP controller supplies TCK, TDI and the capture, shift and update strobes. It also supplies a single select input, which is high only while the coprocessor chain is chosen and the test instruction is loaded. The block returns TDO. A frame whose access flag is set starts one register transaction when it is updated. The transaction then crosses into the core clock domain, runs after a parameterised delay, and reports back through a ready flag that the host reads on a later capture.

The host uses the chain as a polling protocol. It shifts in one frame that carries the direction, the 14-bit packed register address and, for a write, the data. It then shifts NOP frames, which have the access flag clear, until a captured frame shows the ready flag. For a read, the value arrives in the data field of that first ready capture. The register model holds the control register, whose MMU, data-cache and instruction-cache enables drive outputs, two fault-status registers, a fault-address register and a three-bit cache debug control register.

Top module: `cp_scan_chain`

## Requirements
- R1: The frame is 48 bits and is shifted least-significant bit first. Bits 31:0 are data, bit 32 is the access/ready flag, bits 46:33 are the address, and bit 47 is the direction. After a capture, TDO presents captured bit 0 first.
- R2: The address is packed as {op1[2:0], op2[2:0], crn[3:0], crm[3:0]}. The modelled registers sit at these addresses: control 0x0010, data fault status 0x0050, instruction fault status 0x0150, fault address 0x0060, and cache debug control 0x38F0. Each one holds its own value.
- R3: A frame updated with bit 32 clear is a NOP. It changes no register, even when bit 47 is set.
- R4: When bit 32 is set, bit 47 = 1 writes the 32-bit data to the addressed register and bit 47 = 0 reads it.
- R5: While a transaction is pending, a capture loads the whole frame with zeros, so the ready flag reads 0.
- R6: Once the last transaction has completed, a capture loads bit 32 = 1 and bits 47:33 = 0. Bits 31:0 receive the value read for a read and zero for a write, and they do so in the first capture that reports ready.
- R7: Outputs mmu_en_o, dcache_en_o and icache_en_o follow control register bits 0, 2 and 12. They change only when an access executes.
- R8: The cache debug control register keeps data bits 2:0 of a write. Its upper bits always read as zero.
- R9: While sel_i is low, capture, shift and update are ignored and tdo_o is 0.
- R10: A frame with bit 32 set that is updated while a transaction is pending is ignored.
- R11: An access to an unmapped address completes normally. A read of it returns zero, and a write to it changes no modelled register.
- R12: Reset clears every modelled register and all three enable outputs, and leaves the chain ready, so a NOP scan right after reset captures bit 32 = 1 with zero data.
- R13: The access executes LAT core cycles after the core domain detects the request (LAT is 1 to 15). The completion indication changes only when an access executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| tck_i | input | 1 | Test clock |
| sel_i | input | 1 | Chain selected and test instruction loaded |
| capture_i | input | 1 | Capture strobe, sampled on TCK rise |
| shift_i | input | 1 | Shift strobe, sampled on TCK rise |
| update_i | input | 1 | Update strobe, sampled on TCK rise |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| mmu_en_o | output | 1 | Control register bit 0 |
| dcache_en_o | output | 1 | Control register bit 2 |
| icache_en_o | output | 1 | Control register bit 12 |

## Verification
A read result is due at the first capture that occurs after the request has crossed the two-flop synchronizer, waited LAT core cycles and returned through the done synchronizer. The bench therefore never samples at a fixed cycle count. It polls with NOP frames, exactly as a host does, and takes the first capture with the ready flag as the moment both data and completion are due. TCK runs much faster than the core clock, so with LAT = 12 the scan right after a start must come back not ready, and the bench checks the number of polls against the cycle budget. The enable outputs are registered in the core domain, and the bench samples them on a falling core edge after ready has been observed.

// File: rtl/cp_scan_pkg.sv
`timescale 1ns/1ps
package cp_scan_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 14;
  localparam int FRAME_W = DATA_W + ADDR_W + 2;
  localparam int ACC_POS = DATA_W;
  localparam int ADDR_LO = DATA_W + 1;
  localparam int RW_POS  = FRAME_W - 1;

  localparam int NREG     = 5;
  localparam int CTRL_IDX = 0;
  localparam int MMU_BIT  = 0;
  localparam int DC_BIT   = 2;
  localparam int IC_BIT   = 12;
  localparam int CDBG_W   = 3;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } cp_req_t;

  function automatic logic [ADDR_W-1:0] pack_addr(input logic [2:0] op1, input logic [2:0] op2,
                                                  input logic [3:0] crn, input logic [3:0] crm);
    return {op1, op2, crn, crm};
  endfunction

  localparam logic [DATA_W-1:0] FULL_MASK = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] CDBG_MASK = DATA_W'((64'd1 << CDBG_W) - 1);

  // slot 0 control, 1 data fault status, 2 instr fault status, 3 fault address, 4 cache debug
  localparam logic [NREG-1:0][ADDR_W-1:0] REG_ADDR = {
    pack_addr(3'd7, 3'd0, 4'd15, 4'd0),
    pack_addr(3'd0, 3'd0, 4'd6,  4'd0),
    pack_addr(3'd0, 3'd1, 4'd5,  4'd0),
    pack_addr(3'd0, 3'd0, 4'd5,  4'd0),
    pack_addr(3'd0, 3'd0, 4'd1,  4'd0)
  };
  localparam logic [NREG-1:0][DATA_W-1:0] REG_MASK = {
    CDBG_MASK, FULL_MASK, FULL_MASK, FULL_MASK, FULL_MASK
  };
endpackage

// File: rtl/cp_scan_sync.sv
`timescale 1ns/1ps
module cp_scan_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cp_scan_shift.sv
`timescale 1ns/1ps
module cp_scan_shift
  import cp_scan_pkg::*;
(
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              done_tgl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_tgl_o,
  output cp_req_t           req_o,
  output logic              busy_o
);
  logic [FRAME_W-1:0] sr_q;

  // pending while the returned done toggle lags the issued request toggle
  assign busy_o = req_tgl_o ^ done_tgl_i;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      req_tgl_o <= 1'b0;
      req_o     <= '0;
    end else if (sel_i) begin
      if (capture_i) begin
        sr_q <= busy_o ? '0 : {{(FRAME_W-DATA_W-1){1'b0}}, 1'b1, rdata_i};
      end else if (shift_i) begin
        sr_q <= {tdi_i, sr_q[FRAME_W-1:1]};
      end
      if (update_i && sr_q[ACC_POS] && !busy_o) begin
        req_tgl_o   <= ~req_tgl_o;
        req_o.wr    <= sr_q[RW_POS];
        req_o.addr  <= sr_q[ADDR_LO +: ADDR_W];
        req_o.wdata <= sr_q[DATA_W-1:0];
      end
    end
  end

  assign tdo_o = sel_i & sr_q[0];
endmodule

// File: rtl/cp_scan_regfile.sv
`timescale 1ns/1ps
module cp_scan_regfile
  import cp_scan_pkg::*;
#(
  parameter int LAT = 4,
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  cp_req_t           req_i,
  output logic              done_tgl_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              seen_q;
  logic              start, exec;
  logic [NREG-1:0]   hit;
  logic [DATA_W-1:0] slot_val [NREG];
  logic [DATA_W-1:0] rd_val;

  assign start = (req_tgl_i != seen_q) && !busy_o;
  assign exec  = busy_o && (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      busy_o     <= 1'b0;
      cnt_o      <= '0;
      done_tgl_o <= 1'b0;
      rdata_o    <= '0;
    end else if (start) begin
      seen_q <= req_tgl_i;
      busy_o <= 1'b1;
      cnt_o  <= CNT_W'(LAT - 1);
    end else if (exec) begin
      busy_o     <= 1'b0;
      done_tgl_o <= ~done_tgl_o;
      rdata_o    <= req_i.wr ? '0 : rd_val;
    end else if (busy_o) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
    logic [DATA_W-1:0] val_q;
    assign hit[gi] = (req_i.addr == REG_ADDR[gi]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          val_q <= '0;
      else if (exec && req_i.wr && hit[gi]) val_q <= req_i.wdata & REG_MASK[gi];
    end
    assign slot_val[gi] = val_q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rd_val = rd_val | slot_val[i];
    end
  end

  assign ctrl_o = slot_val[CTRL_IDX];
endmodule

// File: rtl/cp_scan_chain.sv
`timescale 1ns/1ps
module cp_scan_chain
  import cp_scan_pkg::*;
#(
  parameter int LAT         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tck_i,
  input  logic sel_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic tdi_i,
  output logic tdo_o,
  output logic mmu_en_o,
  output logic dcache_en_o,
  output logic icache_en_o
);
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

  logic              req_tgl, req_tgl_s;
  logic              done_tgl, done_tgl_s;
  logic              busy_tck, busy_core;
  cp_req_t           req;
  logic [DATA_W-1:0] rdata, ctrl;
  logic [CNT_W-1:0]  core_cnt;

  cp_scan_shift u_shift (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .update_i   (update_i),
    .tdi_i      (tdi_i),
    .tdo_o      (tdo_o),
    .done_tgl_i (done_tgl_s),
    .rdata_i    (rdata),
    .req_tgl_o  (req_tgl),
    .req_o      (req),
    .busy_o     (busy_tck)
  );

  cp_scan_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_tgl),
    .q_o    (req_tgl_s)
  );

  cp_scan_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .d_i    (done_tgl),
    .q_o    (done_tgl_s)
  );

  cp_scan_regfile #(.LAT(LAT)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_tgl_i  (req_tgl_s),
    .req_i      (req),
    .done_tgl_o (done_tgl),
    .rdata_o    (rdata),
    .ctrl_o     (ctrl),
    .busy_o     (busy_core),
    .cnt_o      (core_cnt)
  );

  assign mmu_en_o    = ctrl[MMU_BIT];
  assign dcache_en_o = ctrl[DC_BIT];
  assign icache_en_o = ctrl[IC_BIT];
endmodule

// File: rtl/cp_scan_chain_chk.sv
`timescale 1ns/1ps
module cp_scan_chain_chk
  import cp_scan_pkg::*;
#(
  parameter int LAT = 4,
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
  input logic             clk_i,
  input logic             tck_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             tdo_o,
  input logic             mmu_en_o,
  input logic             dcache_en_o,
  input logic             icache_en_o,
  input logic             busy_tck,
  input logic             busy_core,
  input logic             req_tgl,
  input cp_req_t          req,
  input logic             done_tgl,
  input logic [CNT_W-1:0] core_cnt
);
  AST_TDO_QUIET: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_i |-> !tdo_o); // R9

  AST_NO_RESTART: assert property (@(posedge tck_i) disable iff (!rst_ni)
    busy_tck |=> $stable(req_tgl)); // R10

  AST_REQ_HELD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    busy_tck |=> $stable(req)); // R10

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(core_cnt) <= LAT - 1); // R13

  AST_DONE_ON_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_core |=> $stable(done_tgl)); // R13

  AST_ENABLES_ON_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_core |=> $stable({mmu_en_o, dcache_en_o, icache_en_o})); // R7
endmodule

bind cp_scan_chain cp_scan_chain_chk #(.LAT(LAT)) u_chk (
  .clk_i       (clk_i),
  .tck_i       (tck_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .tdo_o       (tdo_o),
  .mmu_en_o    (mmu_en_o),
  .dcache_en_o (dcache_en_o),
  .icache_en_o (icache_en_o),
  .busy_tck    (busy_tck),
  .busy_core   (busy_core),
  .req_tgl     (req_tgl),
  .req         (req),
  .done_tgl    (done_tgl),
  .core_cnt    (core_cnt)
);

// File: tb/cp_scan_chain_tb_top.sv
`timescale 1ns/1ps
module cp_scan_chain_tb_top;
  localparam int LAT      = 12;
  localparam int TCK_HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, tck = 1'b0;
  logic sel = 1'b0, cap_s = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic tdo, mmu, dc, ic;

  int total = 0, bad = 0, polls = 0;
  logic [47:0] cap_v;
  logic [31:0] mdl [5];
  localparam logic [13:0] ADR [5] = '{14'h0010, 14'h0050, 14'h0150, 14'h0060, 14'h38F0};

  always #10 clk = ~clk;

  cp_scan_chain #(.LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tck_i(tck), .sel_i(sel), .capture_i(cap_s),
    .shift_i(sh), .update_i(upd), .tdi_i(tdi), .tdo_o(tdo),
    .mmu_en_o(mmu), .dcache_en_o(dc), .icache_en_o(ic)
  );

  function automatic int idx_of(logic [13:0] a);
    for (int i = 0; i < 5; i++) if (ADR[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [31:0] mask_of(int i);
    return (i == 4) ? 32'h7 : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [47:0] frame(logic wr, logic [13:0] a, logic acc, logic [31:0] d);
    return {wr, a, acc, d};
  endfunction

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    #(TCK_HALF) tck = 1'b1;
    #(TCK_HALF) tck = 1'b0;
  endtask

  task automatic scan(input logic s, input logic [47:0] fo, output logic [47:0] fi);
    sel = s; cap_s = 1'b1; tick(); cap_s = 1'b0; sh = 1'b1;
    for (int k = 0; k < 48; k++) begin
      tdi = fo[k]; #1; fi[k] = tdo; tick();
    end
    sh = 1'b0; upd = 1'b1; tick(); upd = 1'b0; sel = 1'b1;
  endtask

  task automatic poll_ready();
    polls = 0;
    do begin
      scan(1'b1, frame(1'b0, 14'h0, 1'b0, 32'h0), cap_v);
      polls++;
    end while (!cap_v[32] && polls < 64);
  endtask

  task automatic access(input logic wr, input logic [13:0] a, input logic [31:0] d);
    logic [47:0] junk;
    int i;
    scan(1'b1, frame(wr, a, 1'b1, d), junk);
    poll_ready();
    i = idx_of(a);
    if (wr && i >= 0) mdl[i] = d & mask_of(i);
  endtask

  task automatic rd_check(string req, logic [13:0] a);
    int i;
    access(1'b0, a, 32'h0);
    i = idx_of(a);
    check(req, cap_v, {15'h0, 1'b1, (i >= 0) ? mdl[i] : 32'h0});
  endtask

  task automatic wr_do(string req, logic [13:0] a, logic [31:0] d);
    access(1'b1, a, d);
    check(req, cap_v, {15'h0, 1'b1, 32'h0});
  endtask

  task automatic out_check(string req);
    @(negedge clk); #1;
    check(req, {45'h0, mmu, dc, ic}, {45'h0, mdl[0][0], mdl[0][2], mdl[0][12]});
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin : watchdog
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog R13 actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin : main
    logic [47:0] junk;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 5; i++) mdl[i] = 32'h0;
    #55 rst_n = 1'b1;
    #13;

    // R12: ready after reset, cleared state
    scan(1'b1, frame(1'b0, 14'h0, 1'b0, 32'h0), cap_v);
    check("R12 ready after reset", cap_v, {15'h0, 1'b1, 32'h0});
    out_check("R12 enables cleared");
    for (int i = 0; i < 5; i++) rd_check("R12 regs cleared", ADR[i]);

    // R4 R7 R1: control write, enables, LSB-first read back
    wr_do("R6 write returns zero", 14'h0010, 32'h0000_1005);
    out_check("R7 all enables set");
    rd_check("R1 R4 control read back", 14'h0010);
    wr_do("R4 control write", 14'h0010, 32'h0000_0004);
    out_check("R7 dcache only");

    // R8: cache debug keeps low three bits
    wr_do("R8 write", 14'h38F0, 32'hFFFF_FFFF);
    rd_check("R8 masked read", 14'h38F0);
    wr_do("R8 write", 14'h38F0, 32'h0000_0005);
    rd_check("R8 masked read 5", 14'h38F0);

    // R2: distinct registers
    wr_do("R2 write", 14'h0050, 32'hA5A5_0001);
    wr_do("R2 write", 14'h0150, 32'h5A5A_0002);
    wr_do("R2 write", 14'h0060, 32'h1234_5678);
    rd_check("R2 data fault status", 14'h0050);
    rd_check("R2 instr fault status", 14'h0150);
    rd_check("R2 fault address", 14'h0060);

    // R3: NOP with write bit does nothing
    scan(1'b1, frame(1'b1, 14'h0050, 1'b0, 32'hDEAD_BEEF), junk);
    rd_check("R3 NOP no write", 14'h0050);

    // R9: deselected scan ignored, tdo quiet
    scan(1'b0, frame(1'b1, 14'h0060, 1'b1, 32'hFFFF_0000), cap_v);
    check("R9 tdo low when deselected", cap_v, 48'h0);
    rd_check("R9 deselected write ignored", 14'h0060);

    // R5 R10 R13: pending start ignored, busy capture
    scan(1'b1, frame(1'b1, 14'h0050, 1'b1, 32'h1111_1111), junk);
    scan(1'b1, frame(1'b1, 14'h0050, 1'b1, 32'h2222_2222), cap_v);
    check("R5 busy capture", cap_v, 48'h0);
    mdl[1] = 32'h1111_1111;
    poll_ready();
    check("R6 ready after write", cap_v, {15'h0, 1'b1, 32'h0});
    rd_check("R10 second start ignored", 14'h0050);

    // R13: first poll busy, ready within budget
    access(1'b1, 14'h0060, 32'h0BAD_F00D);
    total++;
    if (polls < 2 || polls > 4) begin
      bad++;
      $display("FAIL R13 poll count actual=%0d expected=2..4", polls);
    end

    // R11: unmapped
    wr_do("R11 unmapped write completes", 14'h0011, 32'hCAFE_CAFE);
    rd_check("R11 unmapped reads zero", 14'h0011);
    rd_check("R11 control untouched", 14'h0010);

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [13:0] a;
      logic wr;
      logic [31:0] d;
      a  = ($urandom % 4 == 0) ? 14'($urandom) : ADR[$urandom % 5];
      wr = 1'($urandom);
      d  = $urandom;
      if (wr) wr_do("R4 random write", a, d);
      else    rd_check("R6 random read", a);
    end
    out_check("R7 enables after random");
    for (int i = 0; i < 5; i++) rd_check("R2 final state", ADR[i]);

    report();
    $finish;
  end
endmodule